// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the word address for a pipelined burst memory array. Two active-low address strobes can start an access. One comes from the processor and one from a cache controller. When a strobe is accepted, the full input address is registered. Its two low bits also become the starting point of a four-beat burst. After that, each cycle in which the active-low advance input is asserted steps the low bits to the next position in the burst. The upper bits do not change.

The burst order comes from a strap input, which is sampled while reset is held. Strap high gives an interleaved order, where the start value is XORed with a beat count. Strap low gives a linear order, where the beat count is added to the start value modulo four. A load needs all three chip enables active: enable 1 low, enable 2 high and enable 3 low. The processor strobe only counts while enable 1 is low. When it counts, it takes priority over the controller strobe. The array address is a registered output. It reflects the inputs sampled at the previous rising edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and at the first falling edge after a reset edge, `arr_addr` is zero.
- R2: With `proc_stb_n`=0 and all chip enables active (`ce1_n`=0, `ce2`=1, `ce3_n`=0) at a rising edge, `arr_addr` equals `addr_in` after that edge.
- R3: With `ctrl_stb_n`=0, the processor strobe not honoured, and all chip enables active, `arr_addr` equals `addr_in` after that edge.
- R4: When both strobes are low and `ce1_n`=0, only the processor strobe is acted on. If `ce2` or `ce3_n` is then inactive, no load happens and `arr_addr` keeps its value, even though the controller strobe is low.
- R5: While `ce1_n`=1, a low `proc_stb_n` has no effect. With `ctrl_stb_n`=1 and `adv_n`=0, the burst steps exactly as if the processor strobe were high.
- R6: A low controller strobe with any chip enable inactive loads nothing and leaves `arr_addr` unchanged.
- R7: With the strap latched low, each advance sets `arr_addr[1:0]` to (start + beats) mod 4. Example: start 01 gives 10, 11, 00.
- R8: With the strap latched high, each advance sets `arr_addr[1:0]` to start XOR beats. Example: start 10 gives 11, 00, 01.
- R9: The fourth advance after a load returns `arr_addr[1:0]` to the start value.
- R10: `adv_n` is ignored in a cycle where a strobe loads. The loaded address appears with beat zero.
- R11: With no strobe acted on and `adv_n`=1, `arr_addr` holds its value.
- R12: `arr_addr[ADDR_W-1:2]` changes only when an address is loaded.
- R13: `order_sel` is sampled only while `rst` is high. Changing it afterwards does not change the burst order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also latches the order strap |
| addr_in | input | ADDR_W | Word address offered with a strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| arr_addr | output | ADDR_W | Registered array address |

## Verification
Every result in this block lands one rising edge after the inputs that cause it. A load, a step and a hold all appear at `arr_addr` on the edge that samples the strobes and advance. The strap takes effect on the edges where reset is high. The bench changes inputs at the falling edge and updates its behavioural model for the coming rising edge. It then waits through that rising edge and compares `arr_addr` at the next falling edge, so each comparison falls exactly one registered stage after its stimulus.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } act_e;
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
  import burst_pkg::*;
(
  input  logic proc_stb_n,
  input  logic ctrl_stb_n,
  input  logic adv_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  output act_e act
);
  logic selected;
  logic proc_seen;

  always_comb begin
    selected  = ~ce1_n & ce2 & ~ce3_n;
    proc_seen = ~proc_stb_n & ~ce1_n;
    if (proc_seen) begin
      act = selected ? ACT_LOAD : ACT_HOLD;
    end else if (!ctrl_stb_n) begin
      act = selected ? ACT_LOAD : ACT_HOLD;
    end else if (!adv_n) begin
      act = ACT_STEP;
    end else begin
      act = ACT_HOLD;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  act_e              act,
  input  logic [BEAT_W-1:0] start_in,
  output logic [BEAT_W-1:0] start_nxt,
  output logic [BEAT_W-1:0] beat_nxt
);
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;

  always_comb begin
    start_nxt = start_q;
    beat_nxt  = beat_q;
    case (act)
      ACT_LOAD: begin
        start_nxt = start_in;
        beat_nxt  = '0;
      end
      ACT_STEP: beat_nxt = beat_q + 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      start_q <= start_nxt;
      beat_q  <= beat_nxt;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  logic              interleave,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  assign lin_low = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_low[b] = start[b] ^ beat[b];
  end

  assign low = interleave ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  act_e              act;
  logic [BEAT_W-1:0] start_nxt;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [HI_W-1:0]   hi_q;
  logic [HI_W-1:0]   hi_nxt;
  logic              mode_q;

  burst_strobe_arb u_arb (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .adv_n      (adv_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .act        (act)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .start_in  (addr_in[BEAT_W-1:0]),
    .start_nxt (start_nxt),
    .beat_nxt  (beat_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start      (start_nxt),
    .beat       (beat_nxt),
    .interleave (mode_q),
    .low        (low_nxt)
  );

  assign hi_nxt = (act == ACT_LOAD) ? addr_in[ADDR_W-1:BEAT_W] : hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= order_sel;
      hi_q     <= '0;
      arr_addr <= '0;
    end else begin
      hi_q     <= hi_nxt;
      arr_addr <= {hi_nxt, low_nxt};
    end
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic [ADDR_W-1:0] arr_addr
);
  logic sel;
  logic proc_ok;
  logic any_stb;
  assign sel     = ~ce1_n & ce2 & ~ce3_n;
  assign proc_ok = ~proc_stb_n & ~ce1_n;
  assign any_stb = proc_ok | ~ctrl_stb_n;

  p_proc_load_r2: assert property (@(posedge clk) disable iff (rst)
    (proc_ok && sel) |=> (arr_addr == $past(addr_in)));

  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!proc_ok && !ctrl_stb_n && sel) |=> (arr_addr == $past(addr_in)));

  p_proc_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (proc_ok && !sel) |=> $stable(arr_addr));

  p_ctrl_desel_r6: assert property (@(posedge clk) disable iff (rst)
    (!proc_ok && !ctrl_stb_n && !sel) |=> $stable(arr_addr));

  p_step_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (!any_stb && !adv_n) |=> (arr_addr[1:0] != $past(arr_addr[1:0])));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!any_stb && adv_n) |=> $stable(arr_addr));

  p_upper_fixed_r12: assert property (@(posedge clk) disable iff (rst)
    !(any_stb && sel) |=> $stable(arr_addr[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr_in    (addr_in),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .adv_n      (adv_n),
  .ce1_n      (ce1_n),
  .ce2        (ce2),
  .ce3_n      (ce3_n),
  .arr_addr   (arr_addr)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          proc_stb_n = 1'b1;
  logic          ctrl_stb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b1;
  logic          ce1_n = 1'b1;
  logic          ce2 = 1'b0;
  logic          ce3_n = 1'b1;
  logic [AW-1:0] arr_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_addr = 0;
  int m_beat = 0;
  int m_mode = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .addr_in(addr_in), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .order_sel(order_sel),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .arr_addr(arr_addr)
  );

  function automatic logic [AW-1:0] expected();
    int lo;
    int st;
    st = m_addr % 4;
    lo = (m_mode != 0) ? (st ^ m_beat) : ((st + m_beat) % 4);
    return AW'((m_addr / 4) * 4 + lo);
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] exp_v;
    exp_v = expected();
    checks++;
    if (arr_addr !== exp_v) begin
      failures++;
      $display("FAIL %s: arr_addr=%h expected=%h", tag, arr_addr, exp_v);
    end
  endtask

  task automatic do_reset(input logic strap, input string tag);
    rst = 1'b1;
    order_sel = strap;
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    m_addr = 0; m_beat = 0; m_mode = strap;
    repeat (2) @(negedge clk);
    check(tag);
    rst = 1'b0;
  endtask

  task automatic cyc(input logic p, input logic c, input logic a,
                     input logic e1, input logic e2, input logic e3,
                     input logic [AW-1:0] ad, input string tag);
    bit s;
    bit ld;
    proc_stb_n = p; ctrl_stb_n = c; adv_n = a;
    ce1_n = e1; ce2 = e2; ce3_n = e3; addr_in = ad;
    s  = !e1 && e2 && !e3;
    ld = 0;
    if (!p && !e1) ld = s;
    else if (!c) ld = s;
    else if (!a) m_beat = (m_beat + 1) % 4;
    if (ld) begin
      m_addr = int'(ad);
      m_beat = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1, "R1 reset zero");
    cyc(1,1,1, 1,0,1, 16'h0000, "R1 idle after reset");
    cyc(0,1,1, 0,1,0, 16'h1232, "R2 proc load");
    order_sel = 1'b0;
    cyc(1,1,0, 0,1,0, 16'hFFFF, "R8 R12 R13 step 1");
    cyc(1,1,0, 1,0,1, 16'h0000, "R8 R12 step 2");
    cyc(1,1,0, 1,0,1, 16'h0000, "R8 step 3");
    cyc(1,1,0, 1,0,1, 16'h0000, "R9 wrap interleaved");
    cyc(1,1,1, 0,1,0, 16'h7777, "R11 hold");
    cyc(1,1,1, 1,0,1, 16'h7777, "R11 hold 2");
    cyc(1,0,0, 0,1,0, 16'hABC1, "R3 R10 ctrl load, advance ignored");
    cyc(0,0,0, 0,1,0, 16'h5552, "R2 R10 both strobes selected");
    cyc(0,0,1, 0,0,0, 16'h9999, "R4 proc wins deselected");
    cyc(0,0,1, 0,1,1, 16'h9999, "R4 proc wins ce3 off");
    cyc(0,1,0, 1,1,0, 16'h4444, "R5 proc ignored with ce1 high");
    cyc(1,0,1, 0,1,1, 16'h3333, "R6 ctrl with ce3 inactive");
    cyc(1,0,1, 1,1,0, 16'h3333, "R6 ctrl with ce1 inactive");
    cyc(1,0,1, 0,0,0, 16'h3333, "R6 ctrl with ce2 inactive");
    do_reset(1'b0, "R1 reset second");
    order_sel = 1'b1;
    cyc(1,0,1, 0,1,0, 16'h0051, "R3 ctrl load linear");
    cyc(1,1,0, 0,1,0, 16'h0000, "R7 R13 step 1");
    cyc(1,1,0, 0,1,0, 16'h0000, "R7 R12 step 2");
    cyc(1,1,1, 0,1,0, 16'h0000, "R11 suspend");
    cyc(1,1,0, 0,1,0, 16'h0000, "R7 step 3");
    cyc(1,1,0, 0,1,0, 16'h0000, "R9 wrap linear");
    cyc(0,1,0, 0,1,0, 16'hFFFE, "R2 R10 load top");
    cyc(1,1,0, 0,1,0, 16'h0000, "R7 R12 step near top");
    cyc(1,1,0, 0,1,0, 16'h0000, "R7 R12 wrap no carry");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule